// File: doc/BRIEF.md
# LPI Highest-Priority Pending Scanner

This block finds the best pending locality-specific peripheral interrupt (LPI) of one processor. The pending state of the LPIs lives in a bitmap in memory, one bit per interrupt ID. Their settings live in a separate table in memory, one byte per LPI. A full rescan walks the pending bitmap byte by byte and looks at the set bits from the least significant bit upward. For each pending ID it fetches that ID's configuration byte, drops the ID if the byte's enable bit is clear, and otherwise derives a priority and compares it with the best result held so far.

Single-interrupt updates set or clear one pending bit with a read-modify-write of its bitmap byte. Setting a bit costs one extra configuration lookup for that ID. Clearing a bit starts a full rescan only when the cleared ID is the one currently reported as best.

Memory traffic uses two ports. Byte reads use a request/response handshake with at most one read outstanding. Byte writes are single-cycle and have no response. While an operation runs, the block holds `busy_o`, drops `upd_ready_o` and takes no new request. It ends every operation, including an ignored one, with a one-cycle `done_o` pulse. A best priority of 0xFF means that no LPI is pending. The selected LPI always belongs to the non-secure Group 1 class, so the block has no group output.

Top module: `lpi_hpp_scanner`

## Requirements
- R1: A rescan request while `lpi_on_i` is low, or while either base input is zero, issues no memory read and leaves the best ID and priority unchanged. The operation still ends with a `done_o` pulse.
- R2: An enabled rescan first sets the best priority to 0xFF. It then reads every pending byte at `pend_base_i + b`, where b runs from `LPI_BASE/8` to the last byte of the table. It also reads one configuration byte for each set bit it finds.
- R3: With security enabled (`sec_off_i` low), the priority of an LPI is ((cfg AND 0xFC) >> 1) OR 0x80.
- R4: With security disabled (`sec_off_i` high), the priority of an LPI is cfg AND 0xFC.
- R5: The configuration byte of ID n is at `prop_base_i + (n - LPI_BASE)`. Bit 0 of that byte enables the LPI, and a pending ID whose enable bit is clear is never selected.
- R6: The lowest priority value wins. Among pending IDs of equal priority, the lowest ID wins, whether the result comes from a rescan or from incremental updates.
- R7: The effective ID width is the smaller of `id_bits_i` and `MAX_IDB`. The table covers the IDs below 2^(width+1), and pending bits above that limit are never read.
- R8: An update whose ID is below `LPI_BASE` or beyond the table limit, or that arrives while the gating of R1 fails, performs no memory read or write.
- R9: An update reads the byte at `pend_base_i + id/8`. If bit id%8 of that byte already equals `upd_set_i`, nothing is written. Otherwise the byte is written back with only that bit changed.
- R10: An update that sets a pending bit makes one configuration read and compares only that ID against the current best. It reads no other pending byte.
- R11: An update that clears the pending bit of the current best ID starts a full rescan. Clearing any other ID leaves the best unchanged and starts no rescan.
- R12: After reset the block is idle with best priority 0xFF. An accepted request holds `busy_o` high and `upd_ready_o` low until the cycle of its single `done_o` pulse, and the block is idle in the cycle after that pulse.
- R13: The block never issues a read request while an earlier read has not yet received its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prop_base_i | input | AW | Byte address of the configuration table |
| pend_base_i | input | AW | Byte address of the pending bitmap |
| id_bits_i | input | IDBW | Programmed ID width field |
| lpi_on_i | input | 1 | LPI enable |
| sec_off_i | input | 1 | Security disabled, which selects the priority formula |
| rescan_i | input | 1 | Request a full rescan; taken when idle |
| upd_valid_i | input | 1 | Single pending update request |
| upd_id_i | input | IDW | Interrupt ID to update |
| upd_set_i | input | 1 | 1 sets the pending bit, 0 clears it |
| upd_ready_o | output | 1 | Block idle and able to take a request |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | AW | Read byte address |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | 8 | Read response byte |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | 8 | Write byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| best_id_o | output | IDW | Best pending LPI ID |
| best_prio_o | output | 8 | Its priority; 0xFF means none |

## Verification
The bench builds the block with `LPI_BASE` = 8192, `IDW` = 16 and `MAX_IDB` = 13. A rescan therefore walks exactly 1024 pending bytes, which is short enough to run a full rescan more than twenty times in one run. Because `id_bits_i` can still be programmed to 15, the bench can place a pending ID beyond the clamped limit and show that the block ignores it. A bench memory model with read latencies that alternate between short and long answers every access. An arithmetic reference scan over that memory gives the expected winner after each of a sweep of sixteen set updates and sixteen clear updates.

// File: rtl/lpi_scan_pkg.sv
package lpi_scan_pkg;
   typedef enum logic [3:0] {
      S_IDLE,
      S_PRD,
      S_PWAIT,
      S_BITS,
      S_CRD,
      S_CWAIT,
      S_URD,
      S_UWAIT,
      S_UWR,
      S_FIN
   } scan_st_e;

   localparam logic [7:0] PRIO_NONE = 8'hFF;
endpackage

// File: rtl/lpi_low_bit.sv
module lpi_low_bit #(
   parameter int W = 8,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec_i,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/lpi_cfg_decode.sv
module lpi_cfg_decode #(
   parameter logic [7:0] PRIO_MASK = 8'hFC
) (
   input  logic [7:0] cfg_i,
   input  logic       sec_off_i,
   output logic       en_o,
   output logic [7:0] prio_o
);
   logic [7:0] masked;

   assign masked = cfg_i & PRIO_MASK;
   assign en_o   = cfg_i[0];
   assign prio_o = sec_off_i ? masked : {1'b1, masked[7:1]};
endmodule

// File: rtl/lpi_best_track.sv
module lpi_best_track
   import lpi_scan_pkg::*;
#(
   parameter int IDW = 16
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           clr_i,
   input  logic           cand_v_i,
   input  logic [IDW-1:0] cand_id_i,
   input  logic [7:0]     cand_prio_i,
   output logic [IDW-1:0] id_o,
   output logic [7:0]     prio_o
);
   logic wins;

   assign wins = (cand_prio_i < prio_o) ||
                 ((cand_prio_i == prio_o) && (cand_id_i <= id_o));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prio_o <= PRIO_NONE;
         id_o   <= '0;
      end else if (clr_i) begin
         prio_o <= PRIO_NONE;
      end else if (cand_v_i && wins) begin
         prio_o <= cand_prio_i;
         id_o   <= cand_id_i;
      end
   end

   // R2: a rescan start leaves no best
   a_r2_clr_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> prio_o == PRIO_NONE);

   // R6: a candidate never makes the best worse
   a_r6_no_worse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cand_v_i && !clr_i) |=> prio_o <= $past(prio_o));
endmodule

// File: rtl/lpi_hpp_scanner.sv
module lpi_hpp_scanner
   import lpi_scan_pkg::*;
#(
   parameter int AW       = 32,
   parameter int IDW      = 16,
   parameter int IDBW     = 5,
   parameter int MAX_IDB  = 15,
   parameter int LPI_BASE = 8192
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [AW-1:0]   prop_base_i,
   input  logic [AW-1:0]   pend_base_i,
   input  logic [IDBW-1:0] id_bits_i,
   input  logic            lpi_on_i,
   input  logic            sec_off_i,
   input  logic            rescan_i,
   input  logic            upd_valid_i,
   input  logic [IDW-1:0]  upd_id_i,
   input  logic            upd_set_i,
   output logic            upd_ready_o,
   output logic            rd_req_o,
   output logic [AW-1:0]   rd_addr_o,
   input  logic            rd_valid_i,
   input  logic [7:0]      rd_data_i,
   output logic            wr_en_o,
   output logic [AW-1:0]   wr_addr_o,
   output logic [7:0]      wr_data_o,
   output logic            busy_o,
   output logic            done_o,
   output logic [IDW-1:0]  best_id_o,
   output logic [7:0]      best_prio_o
);
   localparam int BW = IDW - 3;
   localparam logic [BW-1:0]   FIRST_BYTE = BW'(LPI_BASE / 8);
   localparam logic [IDW:0]    BASE_W     = (IDW + 1)'(LPI_BASE);
   localparam logic [IDBW-1:0] MAX_F      = IDBW'(MAX_IDB);

   generate
      if (MAX_IDB + 1 > IDW) begin : g_bad_idw
         $error("IDW too narrow for MAX_IDB");
      end
      if (MAX_IDB >= (1 << IDBW)) begin : g_bad_idbw
         $error("IDBW too narrow for MAX_IDB");
      end
      if ((LPI_BASE % 8) != 0 || LPI_BASE >= (1 << IDW)) begin : g_bad_base
         $error("LPI_BASE must be byte aligned and below 2**IDW");
      end
   endgenerate

   scan_st_e       st_q;
   logic [BW-1:0]  byte_q, last_q;
   logic [7:0]     pbyte_q;
   logic [IDW-1:0] cur_id_q;
   logic           lvl_q, scan_mode_q, rd_out_q;

   // table geometry from the live configuration
   logic [IDBW-1:0] eff_idb;
   logic [IDW:0]    id_cnt;
   logic [BW-1:0]   last_byte_c;
   logic            gate_ok, upd_in_range, scan_nonempty;

   assign eff_idb       = (id_bits_i > MAX_F) ? MAX_F : id_bits_i;
   assign id_cnt        = (IDW + 1)'(1) << ({1'b0, eff_idb} + (IDBW + 1)'(1));
   assign last_byte_c   = BW'((id_cnt >> 3) - (IDW + 1)'(1));
   assign gate_ok       = lpi_on_i && (|prop_base_i) && (|pend_base_i);
   assign upd_in_range  = ({1'b0, upd_id_i} < id_cnt) && ({1'b0, upd_id_i} >= BASE_W);
   assign scan_nonempty = id_cnt > BASE_W;

   logic [2:0] low_idx;
   lpi_low_bit #(.W(8)) u_low (
      .vec_i (pbyte_q),
      .idx_o (low_idx)
   );

   logic       cfg_en;
   logic [7:0] cfg_prio;
   lpi_cfg_decode #(.PRIO_MASK(8'hFC)) u_dec (
      .cfg_i     (rd_data_i),
      .sec_off_i (sec_off_i),
      .en_o      (cfg_en),
      .prio_o    (cfg_prio)
   );

   logic cand_v, clr_best, clear_hits_best;
   assign cand_v          = (st_q == S_CWAIT) && rd_valid_i && cfg_en;
   assign clear_hits_best = (st_q == S_UWR) && !lvl_q && (cur_id_q == best_id_o);
   assign clr_best        = ((st_q == S_IDLE) && rescan_i && gate_ok) || clear_hits_best;

   lpi_best_track #(.IDW(IDW)) u_best (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (clr_best),
      .cand_v_i    (cand_v),
      .cand_id_i   (cur_id_q),
      .cand_prio_i (cfg_prio),
      .id_o        (best_id_o),
      .prio_o      (best_prio_o)
   );

   logic [7:0] upd_byte;
   always_comb begin
      upd_byte = rd_data_i;
      upd_byte[cur_id_q[2:0]] = lvl_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q        <= S_IDLE;
         byte_q      <= '0;
         last_q      <= '0;
         pbyte_q     <= '0;
         cur_id_q    <= '0;
         lvl_q       <= 1'b0;
         scan_mode_q <= 1'b0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (rescan_i) begin
                  byte_q <= FIRST_BYTE;
                  last_q <= last_byte_c;
                  st_q   <= (gate_ok && scan_nonempty) ? S_PRD : S_FIN;
               end else if (upd_valid_i) begin
                  cur_id_q <= upd_id_i;
                  lvl_q    <= upd_set_i;
                  st_q     <= (gate_ok && upd_in_range) ? S_URD : S_FIN;
               end
            end
            S_PRD:   st_q <= S_PWAIT;
            S_PWAIT: if (rd_valid_i) begin
               pbyte_q <= rd_data_i;
               st_q    <= S_BITS;
            end
            S_BITS: begin
               if (pbyte_q == 8'd0) begin
                  if (byte_q == last_q) begin
                     st_q <= S_FIN;
                  end else begin
                     byte_q <= byte_q + BW'(1);
                     st_q   <= S_PRD;
                  end
               end else begin
                  cur_id_q    <= {byte_q, low_idx};
                  pbyte_q     <= pbyte_q & ~(8'd1 << low_idx);
                  scan_mode_q <= 1'b1;
                  st_q        <= S_CRD;
               end
            end
            S_CRD:   st_q <= S_CWAIT;
            S_CWAIT: if (rd_valid_i) st_q <= scan_mode_q ? S_BITS : S_FIN;
            S_URD:   st_q <= S_UWAIT;
            S_UWAIT: if (rd_valid_i) begin
               if (rd_data_i[cur_id_q[2:0]] == lvl_q) begin
                  st_q <= S_FIN;
               end else begin
                  pbyte_q <= upd_byte;
                  st_q    <= S_UWR;
               end
            end
            S_UWR: begin
               if (lvl_q) begin
                  scan_mode_q <= 1'b0;
                  st_q        <= S_CRD;
               end else if (clear_hits_best) begin
                  byte_q <= FIRST_BYTE;
                  last_q <= last_byte_c;
                  st_q   <= S_PRD;
               end else begin
                  st_q <= S_FIN;
               end
            end
            S_FIN:   st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_req_o  = 1'b0;
      rd_addr_o = '0;
      unique case (st_q)
         S_PRD: begin
            rd_req_o  = 1'b1;
            rd_addr_o = pend_base_i + AW'(byte_q);
         end
         S_CRD: begin
            rd_req_o  = 1'b1;
            rd_addr_o = prop_base_i + AW'(cur_id_q - IDW'(LPI_BASE));
         end
         S_URD: begin
            rd_req_o  = 1'b1;
            rd_addr_o = pend_base_i + AW'(cur_id_q[IDW-1:3]);
         end
         default: ;
      endcase
   end

   assign wr_en_o     = (st_q == S_UWR);
   assign wr_addr_o   = pend_base_i + AW'(cur_id_q[IDW-1:3]);
   assign wr_data_o   = pbyte_q;
   assign busy_o      = (st_q != S_IDLE);
   assign done_o      = (st_q == S_FIN);
   assign upd_ready_o = (st_q == S_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         rd_out_q <= 1'b0;
      else if (rd_req_o)   rd_out_q <= 1'b1;
      else if (rd_valid_i) rd_out_q <= 1'b0;
   end

   // R13: a single read in flight
   a_r13_one_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req_o |-> !rd_out_q);

   // R12: the done pulse returns the block to idle
   a_r12_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !busy_o);

   // R9: a bitmap write always follows a read response
   a_r9_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |-> $past(rd_valid_i));

   // R3: with security on, every candidate priority has its top bit set
   a_r3_ns_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cand_v && !sec_off_i) |-> cfg_prio[7]);
endmodule

// File: tb/tb_lpi_hpp_scanner.sv
module tb_lpi_hpp_scanner;
   localparam int AW = 32, IDW = 16, IDBW = 5, MAX_IDB = 13, LBASE = 8192;
   localparam int PEND = 32'h1000, PROP = 32'h4000;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [AW-1:0] prop_base = PROP, pend_base = PEND;
   logic [IDBW-1:0] id_bits = 5'd13;
   logic lpi_on = 1'b1, sec_off = 1'b0, rescan = 1'b0, upd_valid = 1'b0, upd_set = 1'b0;
   logic [IDW-1:0] upd_id = '0;
   logic upd_ready, rd_req, rd_valid, wr_en, busy, done;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [7:0] rd_data, wr_data, best_prio;
   logic [IDW-1:0] best_id;

   lpi_hpp_scanner #(.AW(AW), .IDW(IDW), .IDBW(IDBW), .MAX_IDB(MAX_IDB), .LPI_BASE(LBASE)) dut (
      .clk_i(clk), .rst_ni(rst_n), .prop_base_i(prop_base), .pend_base_i(pend_base),
      .id_bits_i(id_bits), .lpi_on_i(lpi_on), .sec_off_i(sec_off), .rescan_i(rescan),
      .upd_valid_i(upd_valid), .upd_id_i(upd_id), .upd_set_i(upd_set), .upd_ready_o(upd_ready),
      .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .busy_o(busy), .done_o(done),
      .best_id_o(best_id), .best_prio_o(best_prio));

   // memory model: alternating read latency, bench pokes and wipe
   logic [7:0] mem [0:32767];
   logic pend_rd = 1'b0, lat_sel = 1'b0, poke_en = 1'b0, wipe = 1'b0;
   logic [1:0] lat_cnt = '0;
   logic [14:0] pa = '0, poke_addr = '0;
   logic [7:0] poke_data = '0;
   int n_rd = 0, n_wr = 0;

   initial begin rd_valid = 1'b0; rd_data = '0; end

   always @(posedge clk) begin
      rd_valid <= 1'b0;
      if (wipe) begin
         for (int i = 0; i < 32768; i++) mem[i] <= 8'd0;
      end
      if (poke_en) mem[poke_addr] <= poke_data;
      if (rd_req) begin
         pend_rd <= 1'b1;
         pa      <= rd_addr[14:0];
         lat_cnt <= lat_sel ? 2'd2 : 2'd0;
         lat_sel <= ~lat_sel;
         n_rd    <= n_rd + 1;
      end else if (pend_rd) begin
         if (lat_cnt == 2'd0) begin
            rd_valid <= 1'b1;
            rd_data  <= mem[pa];
            pend_rd  <= 1'b0;
         end else begin
            lat_cnt <= lat_cnt - 2'd1;
         end
      end
      if (wr_en) begin
         mem[wr_addr[14:0]] <= wr_data;
         n_wr <= n_wr + 1;
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic poke(input int addr, input int data);
      @(negedge clk);
      poke_en = 1'b1; poke_addr = 15'(addr); poke_data = 8'(data);
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   task automatic poke_pend(input int id);
      int a;
      a = PEND + id / 8;
      poke(a, int'(mem[a]) | (1 << (id % 8)));
   endtask

   task automatic finish_op(input string tag);
      int k;
      k = 0;
      chk(busy && !upd_ready, {tag, " R12 busy"}, {busy, upd_ready}, 2);
      while (!done && k < 20000) begin
         @(negedge clk);
         k++;
      end
      chk(done, {tag, " R12 done"}, done, 1);
      @(negedge clk);
      chk(!busy, {tag, " R12 idle"}, busy, 0);
   endtask

   task automatic do_scan(input string tag);
      @(negedge clk);
      rescan = 1'b1;
      @(negedge clk);
      rescan = 1'b0;
      finish_op(tag);
   endtask

   task automatic do_upd(input int id, input bit lvl, input string tag);
      @(negedge clk);
      upd_valid = 1'b1; upd_id = IDW'(id); upd_set = lvl;
      @(negedge clk);
      upd_valid = 1'b0;
      finish_op(tag);
   endtask

   // reference scan computed from the requirements
   task automatic ref_best(output int ep, output int eid);
      int lim, idb, c, p;
      idb = (int'(id_bits) > MAX_IDB) ? MAX_IDB : int'(id_bits);
      lim = 1 << (idb + 1);
      ep = 255; eid = -1;
      for (int id = LBASE; id < lim; id++) begin
         if (mem[PEND + id / 8][id % 8]) begin
            c = int'(mem[PROP + id - LBASE]);
            if (c % 2 == 1) begin
               p = sec_off ? (c & 'hFC) : (((c & 'hFC) >> 1) | 'h80);
               if (p < ep) begin ep = p; eid = id; end
            end
         end
      end
   endtask

   task automatic cmp_ref(input string tag);
      int ep, eid;
      ref_best(ep, eid);
      chk(int'(best_prio) == ep, {tag, " prio"}, best_prio, ep);
      if (ep != 255) chk(int'(best_id) == eid, {tag, " id"}, best_id, eid);
   endtask

   task automatic set_cfg(input int id, input int cfg);
      poke(PROP + id - LBASE, cfg);
   endtask

   initial begin
      int r0, w0, sid, scfg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(best_prio == 8'hFF, "R12 reset prio", best_prio, 'hFF);
      chk(!busy && upd_ready && !done, "R12 reset idle", {busy, upd_ready, done}, 2);
      wipe = 1'b1;
      @(negedge clk);
      wipe = 1'b0;

      // R1 gating
      lpi_on = 1'b0; r0 = n_rd;
      do_scan("R1 off");
      chk(n_rd == r0, "R1 no reads", n_rd - r0, 0);
      lpi_on = 1'b1; pend_base = '0; r0 = n_rd;
      do_scan("R1 base0");
      chk(n_rd == r0 && best_prio == 8'hFF, "R1 unchanged", n_rd - r0, 0);
      pend_base = PEND;

      // pattern A, security on
      set_cfg(8192, 'h41); poke_pend(8192);
      set_cfg(8193, 'h91); poke_pend(8193);
      set_cfg(8200, 'h04); poke_pend(8200);
      set_cfg(9000, 'h21); poke_pend(9000);
      set_cfg(12345, 'h21); poke_pend(12345);
      set_cfg(16383, 'hA1); poke_pend(16383);
      r0 = n_rd;
      do_scan("R2 scan");
      chk(n_rd - r0 == 1030, "R2 read count", n_rd - r0, 1030);
      chk(best_prio == 8'h90, "R3 secure prio", best_prio, 'h90);
      chk(best_id == 16'd9000, "R5 R6 winner", best_id, 9000);
      cmp_ref("R3 ref");

      // security off
      sec_off = 1'b1;
      do_scan("R4 scan");
      chk(best_prio == 8'h20, "R4 plain prio", best_prio, 'h20);
      chk(best_id == 16'd9000, "R6 tie lowest", best_id, 9000);

      // R7 clamp
      id_bits = 5'd15;
      set_cfg(20000, 'h01); poke_pend(20000);
      r0 = n_rd;
      do_scan("R7 scan");
      chk(n_rd - r0 == 1030, "R7 clamped reads", n_rd - r0, 1030);
      chk(best_id == 16'd9000 && best_prio == 8'h20, "R7 beyond ignored", best_id, 9000);
      id_bits = 5'd13;

      // R8 ignored updates
      r0 = n_rd; w0 = n_wr;
      do_upd(100, 1'b1, "R8 low");
      do_upd(20000, 1'b0, "R8 high");
      chk(n_rd == r0 && n_wr == w0, "R8 no access", n_rd - r0 + n_wr - w0, 0);
      chk(mem[PEND + 20000 / 8][20000 % 8] == 1'b1, "R8 bit kept", 0, 1);

      // R9 equal level
      r0 = n_rd; w0 = n_wr;
      do_upd(9000, 1'b1, "R9 same");
      chk(n_rd - r0 == 1 && n_wr == w0, "R9 no write", n_wr - w0, 0);

      // R10 set path
      set_cfg(8300, 'h11); set_cfg(8400, 'h31); set_cfg(8250, 'h11);
      r0 = n_rd; w0 = n_wr;
      do_upd(8300, 1'b1, "R10 set");
      chk(n_rd - r0 == 2 && n_wr - w0 == 1, "R10 two reads", n_rd - r0, 2);
      chk(mem[PEND + 8300 / 8] == 8'h10, "R9 byte written", mem[PEND + 8300 / 8], 'h10);
      chk(best_id == 16'd8300 && best_prio == 8'h10, "R10 better", best_id, 8300);
      do_upd(8400, 1'b1, "R10 worse");
      chk(best_id == 16'd8300, "R10 worse kept", best_id, 8300);
      do_upd(8250, 1'b1, "R6 tie");
      chk(best_id == 16'd8250 && best_prio == 8'h10, "R6 tie lower id", best_id, 8250);

      // R11 clear path
      r0 = n_rd; w0 = n_wr;
      do_upd(8300, 1'b0, "R11 other");
      chk(n_rd - r0 == 1 && n_wr - w0 == 1, "R11 no rescan", n_rd - r0, 1);
      chk(best_id == 16'd8250, "R11 best kept", best_id, 8250);
      r0 = n_rd;
      do_upd(8250, 1'b0, "R11 best");
      chk(n_rd - r0 == 1032, "R11 rescan reads", n_rd - r0, 1032);
      chk(best_id == 16'd9000 && best_prio == 8'h20, "R11 new best", best_id, 9000);

      // sweep of set then clear updates against the reference scan
      for (int k = 1; k <= 16; k++) begin
         sid  = LBASE + (k * 509) % 8192;
         scfg = ((k * 37) & 'hFC) | ((k % 5 != 0) ? 1 : 0);
         set_cfg(sid, scfg);
         do_upd(sid, 1'b1, "R10 sweep");
         cmp_ref("R6 sweep set");
      end
      for (int k = 1; k <= 16; k++) begin
         sid = LBASE + (k * 509) % 8192;
         do_upd(sid, 1'b0, "R11 sweep");
         cmp_ref("R11 sweep clear");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R12 actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule